// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block manages the low-power halt state of a small processor core. The core raises a one-cycle `sleep_req` strobe when it executes its sleep instruction. If no enabled interrupt is waiting, the controller halts the core and stops the oscillator. It then waits for one of three wake events: an enabled interrupt, a watchdog timeout or an external reset request. Two status bits tell software what happened. `awake_stat` is set at power-up and is cleared by an accepted sleep. `wdt_ok_stat` is set by an accepted sleep and is cleared by any watchdog timeout.

The watchdog is an internal free-running prescaler followed by a counter. A clear strobe from the core restarts it, and so do an accepted sleep and every wake. When it times out while the core runs, it requests a device reset. When it times out during sleep, it only wakes the core.

A wake brought about by an interrupt does not depend on the global interrupt enable `gie`. That enable decides only the path taken after the wake. With `gie` clear, the core continues at the next instruction. With `gie` set, the core runs that instruction and then branches to the interrupt vector. `wake_vec` reports this choice.

The state machine has four states:
- RUN: the core executes.
- SLEEP: the oscillator is off and the core is halted.
- WAKE_OSC: the oscillator is back on and the core is still halted.
- WAKE_GO: the halt is released and `wake_go` pulses.

It has these transitions:
- RUN to SLEEP: sleep accepted.
- RUN to RUN: sleep turned into a no-op, awake timeout, or external reset.
- SLEEP to WAKE_OSC: interrupt wake or watchdog wake.
- SLEEP to RUN: external reset.
- WAKE_OSC to WAKE_GO: always, unless an external reset sends it to RUN.
- WAKE_GO to RUN: always.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `awake_stat`=1, `wdt_ok_stat`=1, `osc_en`=1, `core_halt`=0, `wake_go`=0, `wake_vec`=0, `dev_reset`=0 and `wdt_count`=0.
- R2: A sleep request in RUN with no enabled interrupt pending is accepted at that edge. From the next cycle, `awake_stat`=0, `wdt_ok_stat`=1, `osc_en`=0 and `core_halt`=1. The watchdog restarts from zero and keeps counting during sleep.
- R3: A sleep request in RUN while some bit i has `irq_en[i]` and `irq_flag[i]` both 1 is a no-op. The core is not halted, `awake_stat` and `wdt_ok_stat` do not change, and the watchdog count is not cleared.
- R4: During sleep, any bit i with both `irq_en[i]` and `irq_flag[i]` at 1 wakes the core, whatever `gie` is. A flag whose enable bit is 0 does not wake it.
- R5: On a wake into WAKE_OSC, `osc_en` returns to 1 one cycle before `core_halt` falls. `wake_go` is 1 for exactly the one cycle in which `core_halt` first reads 0.
- R6: `wake_vec` takes the value of `gie` on an interrupt wake. It is 0 after a watchdog wake, and it keeps its value until the next accepted sleep, external reset or awake timeout.
- R7: A watchdog timeout during sleep wakes the core with `wdt_ok_stat`=0 and `awake_stat` left at 0, and raises no `dev_reset`. The timeout comes 2^(PRE_W+CNT_W) edges after the clear.
- R8: An external reset request during sleep returns the FSM straight to RUN with `dev_reset`=1 and `core_halt`=0. It produces no `wake_go` and leaves `awake_stat` and `wdt_ok_stat` unchanged.
- R9: The watchdog count reads 0 in the first cycle of every wake, whatever the wake source.
- R10: `clrwdt_req` clears both the prescaler and the counter. After a clear, `wdt_count` equals floor(k / 2^PRE_W) k edges later.
- R11: A watchdog timeout in RUN, reached 2^(PRE_W+CNT_W) edges after a clear, gives a one-cycle `dev_reset` pulse, sets `wdt_ok_stat`=0 and `awake_stat`=1, and restarts the watchdog.
- R12: `irq_flag` and `ext_rst_req` pass through a two-flop synchronizer. A change takes effect at the third rising edge after it is applied.
- R13: When an external reset request and an enabled interrupt both arrive during sleep, the external reset wins and no `wake_go` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req | input | 1 | One-cycle strobe: sleep instruction executed |
| clrwdt_req | input | 1 | One-cycle strobe: clear the watchdog |
| ext_rst_req | input | 1 | External reset request, asynchronous |
| gie | input | 1 | Global interrupt enable from the core |
| irq_en | input | N_IRQ | Per-source interrupt enable bits |
| irq_flag | input | N_IRQ | Per-source interrupt flag bits, asynchronous |
| awake_stat | output | 1 | 1 at power-up, 0 after an accepted sleep, 1 after an awake timeout |
| wdt_ok_stat | output | 1 | 0 after a watchdog timeout, 1 after an accepted sleep |
| osc_en | output | 1 | Oscillator enable |
| core_halt | output | 1 | Holds the core stopped |
| wake_go | output | 1 | One-cycle pulse when the core resumes after a wake |
| wake_vec | output | 1 | 1 when the current wake takes the interrupt-vector path |
| dev_reset | output | 1 | Device reset request |
| wdt_count | output | CNT_W | Watchdog counter value |

## Verification
The main sleep path is driven from several starting conditions:
- A flag that is already enabled and pending when the sleep request arrives. This separates the no-op case from a real sleep, because the watchdog count and the status bits must stay untouched.
- A flag that is raised only after sleep begins. This must wake the core.
- A flag whose enable bit is clear. This must leave the core asleep.

Random trials draw the enable masks, the pre-existing flags and `gie`, and a bench function predicts whether each sleep is taken and which wake path follows. Directed cases cover the rest:
- The exact watchdog periods, asleep and awake.
- The three-edge synchronizer latency.
- An external reset alone during sleep.
- An external reset arriving together with an interrupt.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_WAKE_OSC,
        ST_WAKE_GO
    } slp_state_e;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_IRQ,
        WK_WDT,
        WK_EXT
    } wake_src_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/slp_wdt.sv
module slp_wdt #(
    parameter int PRE_W = 3,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic             tick,
    output logic [CNT_W-1:0] count
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    assign tick  = (&pre_q) && (&cnt_q);
    assign count = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            if (&pre_q) cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: a clear empties both prescaler and counter on the next cycle
    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && pre_q == '0));

    // R11: the terminal count rolls back to zero
    p_tick_wraps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (cnt_q == '0 && pre_q == '0));
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic clrwdt_req,
    input  logic ext_rst,
    input  logic irq_pend,
    input  logic gie,
    input  logic wdt_tick,
    output logic wdt_clr,
    output logic awake_stat,
    output logic wdt_ok_stat,
    output logic osc_en,
    output logic core_halt,
    output logic wake_go,
    output logic wake_vec,
    output logic dev_reset
);
    slp_state_e state_q, state_n;
    wake_src_e  wake_src;
    logic       accept;
    logic       awake_to;

    // next-state and transition decode
    always_comb begin
        state_n  = state_q;
        wake_src = WK_NONE;
        accept   = 1'b0;
        awake_to = 1'b0;
        if (ext_rst) begin
            state_n = ST_RUN;
            if (state_q == ST_SLEEP) wake_src = WK_EXT;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (wdt_tick) begin
                        awake_to = 1'b1;
                    end else if (sleep_req && !irq_pend) begin
                        state_n = ST_SLEEP;
                        accept  = 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (irq_pend) begin
                        state_n  = ST_WAKE_OSC;
                        wake_src = WK_IRQ;
                    end else if (wdt_tick) begin
                        state_n  = ST_WAKE_OSC;
                        wake_src = WK_WDT;
                    end
                end
                ST_WAKE_OSC: state_n = ST_WAKE_GO;
                ST_WAKE_GO:  state_n = ST_RUN;
            endcase
        end
    end

    assign wdt_clr = ext_rst || accept || awake_to || clrwdt_req ||
                     (wake_src != WK_NONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_n;
    end

    // state-decoded outputs
    always_comb begin
        osc_en    = 1'b1;
        core_halt = 1'b0;
        wake_go   = 1'b0;
        unique case (state_q)
            ST_RUN:      ;
            ST_SLEEP:    begin osc_en = 1'b0; core_halt = 1'b1; end
            ST_WAKE_OSC: core_halt = 1'b1;
            ST_WAKE_GO:  wake_go = 1'b1;
        endcase
    end

    // status and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            awake_stat  <= 1'b1;
            wdt_ok_stat <= 1'b1;
            wake_vec    <= 1'b0;
            dev_reset   <= 1'b0;
        end else begin
            dev_reset <= ext_rst || awake_to;
            if (accept) begin
                awake_stat  <= 1'b0;
                wdt_ok_stat <= 1'b1;
                wake_vec    <= 1'b0;
            end
            if (wake_src == WK_WDT) wdt_ok_stat <= 1'b0;
            if (wake_src == WK_IRQ) wake_vec <= gie;
            if (awake_to) begin
                awake_stat  <= 1'b1;
                wdt_ok_stat <= 1'b0;
                wake_vec    <= 1'b0;
            end
            if (ext_rst) wake_vec <= 1'b0;
        end
    end

    // R2: accepted sleep updates status and halts
    p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req && !irq_pend && !ext_rst && !wdt_tick)
        |=> (!awake_stat && wdt_ok_stat && !osc_en && core_halt));

    // R3: a pending enabled interrupt turns sleep into a no-op
    p_sleep_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req && irq_pend && !ext_rst && !wdt_tick)
        |=> ($stable(awake_stat) && $stable(wdt_ok_stat) && !core_halt));

    // R4: enabled interrupt wakes from sleep
    p_irq_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && irq_pend && !ext_rst) |=> (osc_en && core_halt));

    // R5: oscillator runs for a cycle before the halt is released
    p_osc_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_halt) && !dev_reset) |-> ($past(osc_en) && wake_go));

    // R6: vector path follows the global enable on an interrupt wake
    p_vec_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && irq_pend && !ext_rst) |=> (wake_vec == $past(gie)));

    // R7: watchdog wake records the timeout without a reset
    p_wdt_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && wdt_tick && !irq_pend && !ext_rst)
        |=> (!wdt_ok_stat && !awake_stat && !dev_reset));

    // R8: external reset returns to run and requests a device reset
    p_ext_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> (dev_reset && !core_halt && !wake_go));

    // R11: awake timeout raises a reset and records it
    p_awake_to_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wdt_tick && !ext_rst)
        |=> (dev_reset && !wdt_ok_stat && awake_stat));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
    parameter int N_IRQ = 4,
    parameter int PRE_W = 3,
    parameter int CNT_W = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             clrwdt_req,
    input  logic             ext_rst_req,
    input  logic             gie,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_flag,
    output logic             awake_stat,
    output logic             wdt_ok_stat,
    output logic             osc_en,
    output logic             core_halt,
    output logic             wake_go,
    output logic             wake_vec,
    output logic             dev_reset,
    output logic [CNT_W-1:0] wdt_count
);
    localparam int SYNC_W = N_IRQ + 1;

    logic [SYNC_W-1:0] async_in, sync_out;
    logic [N_IRQ-1:0]  flag_s;
    logic              ext_s;
    logic              irq_pend;
    logic              wdt_clr, wdt_tick;

    assign async_in = {ext_rst_req, irq_flag};
    assign flag_s   = sync_out[N_IRQ-1:0];
    assign ext_s    = sync_out[SYNC_W-1];
    assign irq_pend = |(irq_en & flag_s);

    slp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (sync_out)
    );

    slp_wdt #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_wdt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wdt_clr),
        .tick  (wdt_tick),
        .count (wdt_count)
    );

    slp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .clrwdt_req  (clrwdt_req),
        .ext_rst     (ext_s),
        .irq_pend    (irq_pend),
        .gie         (gie),
        .wdt_tick    (wdt_tick),
        .wdt_clr     (wdt_clr),
        .awake_stat  (awake_stat),
        .wdt_ok_stat (wdt_ok_stat),
        .osc_en      (osc_en),
        .core_halt   (core_halt),
        .wake_go     (wake_go),
        .wake_vec    (wake_vec),
        .dev_reset   (dev_reset)
    );

    // R9: the watchdog reads zero in the first cycle of every wake
    p_wdt_zero_on_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (wdt_count == '0));

    // R13: external reset beats an interrupt wake
    p_ext_priority_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt && !osc_en && ext_s && irq_pend) |=> (!core_halt && !wake_go));
endmodule

// File: tb/tb_sleep_wake_ctrl.sv
module tb_sleep_wake_ctrl;
    localparam int N_IRQ  = 4;
    localparam int PRE_W  = 3;
    localparam int CNT_W  = 6;
    localparam int PERIOD = 1 << (PRE_W + CNT_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, clrwdt_req = 1'b0, ext_rst_req = 1'b0, gie = 1'b0;
    logic [N_IRQ-1:0] irq_en = '0, irq_flag = '0;
    logic awake_stat, wdt_ok_stat, osc_en, core_halt, wake_go, wake_vec, dev_reset;
    logic [CNT_W-1:0] wdt_count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sleep_wake_ctrl #(.N_IRQ(N_IRQ), .PRE_W(PRE_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .clrwdt_req(clrwdt_req),
        .ext_rst_req(ext_rst_req), .gie(gie), .irq_en(irq_en), .irq_flag(irq_flag),
        .awake_stat(awake_stat), .wdt_ok_stat(wdt_ok_stat), .osc_en(osc_en),
        .core_halt(core_halt), .wake_go(wake_go), .wake_vec(wake_vec),
        .dev_reset(dev_reset), .wdt_count(wdt_count)
    );

    function automatic bit exp_pending(input logic [N_IRQ-1:0] en, input logic [N_IRQ-1:0] fl);
        return |(en & fl);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_osc(output int n);
        n = 0;
        while (!osc_en && n < 2000) begin step(1); n++; end
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    endtask

    task automatic pulse_clr();
        clrwdt_req = 1'b1; step(1); clrwdt_req = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        bit seen;
        logic ap, wo;
        void'($urandom(32'd4711));
        step(3);
        // R1 reset values
        chk("R1 awake_stat", awake_stat, 1);
        chk("R1 wdt_ok_stat", wdt_ok_stat, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 core_halt", core_halt, 0);
        chk("R1 wake_go", wake_go, 0);
        chk("R1 wake_vec", wake_vec, 0);
        chk("R1 dev_reset", dev_reset, 0);
        chk("R1 wdt_count", wdt_count, 0);
        rst_n = 1'b1;
        step(2);

        // R10 clear and prescaled counting
        pulse_clr();
        step(20);
        chk("R10 count after 20", wdt_count, 20 >> PRE_W);

        // R2 sleep entry
        pulse_sleep();
        chk("R2 awake_stat", awake_stat, 0);
        chk("R2 wdt_ok_stat", wdt_ok_stat, 1);
        chk("R2 osc_en", osc_en, 0);
        chk("R2 core_halt", core_halt, 1);
        chk("R2 wdt cleared", wdt_count, 0);
        step(16);
        chk("R2 wdt runs in sleep", wdt_count, 16 >> PRE_W);

        // R4/R12/R5/R9 interrupt wake with gie clear
        gie = 1'b0; irq_en = 4'b0010; irq_flag = 4'b0010;
        wait_osc(n);
        chk("R12 sync latency", n, 3);
        chk("R5 halt held with osc on", core_halt, 1);
        chk("R9 wdt zero on wake", wdt_count, 0);
        step(1);
        chk("R5 halt released", core_halt, 0);
        chk("R5 wake_go", wake_go, 1);
        chk("R6 vec with gie=0", wake_vec, 0);
        chk("R4 wdt_ok_stat kept", wdt_ok_stat, 1);
        step(1);
        chk("R5 wake_go one cycle", wake_go, 0);
        irq_flag = '0; step(3);

        // R4 masked flag does not wake; then gie=1 wake
        irq_en = 4'b0001; pulse_sleep();
        irq_flag = 4'b0010; step(30);
        chk("R4 masked flag no wake", osc_en, 0);
        gie = 1'b1; irq_flag = 4'b0011;
        wait_osc(n);
        chk("R4 wake with gie=1", n, 3);
        step(1);
        chk("R6 vec with gie=1", wake_vec, 1);
        irq_flag = '0; gie = 1'b0; step(5);
        chk("R6 vec held", wake_vec, 1);

        // R3 sleep as no-op
        irq_en = 4'b0100; irq_flag = 4'b0100; step(3);
        pulse_clr(); step(12);
        ap = awake_stat; wo = wdt_ok_stat;
        pulse_sleep();
        chk("R3 no halt", core_halt, 0);
        chk("R3 osc on", osc_en, 1);
        chk("R3 awake_stat unchanged", awake_stat, ap);
        chk("R3 wdt_ok_stat unchanged", wdt_ok_stat, wo);
        chk("R3 wdt not cleared", wdt_count, 13 >> PRE_W);
        irq_flag = '0; irq_en = '0; step(3);

        // R7 watchdog wake in sleep
        pulse_clr();
        sleep_req = 1'b1; n = 0; seen = 1'b0;
        do begin
            step(1); sleep_req = 1'b0; n++;
            if (dev_reset) seen = 1'b1;
        end while (!osc_en && n < 2000);
        chk("R7 wake period", n, PERIOD + 1);
        chk("R7 wdt_ok_stat cleared", wdt_ok_stat, 0);
        chk("R7 awake_stat stays", awake_stat, 0);
        chk("R7 no dev_reset", seen, 0);
        chk("R6 vec zero on wdt wake", wake_vec, 0);
        chk("R9 wdt zero on wdt wake", wdt_count, 0);
        step(1);
        chk("R7 resumes", wake_go, 1);
        step(2);

        // R8 external reset in sleep
        pulse_sleep(); step(5);
        ext_rst_req = 1'b1; n = 0; seen = 1'b0;
        while (core_halt && n < 20) begin step(1); n++; if (wake_go) seen = 1'b1; end
        chk("R8 ext latency", n, 3);
        chk("R8 dev_reset", dev_reset, 1);
        chk("R8 no wake_go", seen, 0);
        chk("R8 awake_stat unchanged", awake_stat, 0);
        chk("R8 wdt_ok_stat unchanged", wdt_ok_stat, 1);
        ext_rst_req = 1'b0; step(4);
        chk("R8 dev_reset ends", dev_reset, 0);

        // R13 ext beats interrupt
        pulse_sleep(); step(4);
        ext_rst_req = 1'b1; irq_en = 4'b1000; irq_flag = 4'b1000; gie = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin step(1); if (wake_go) seen = 1'b1; end
        chk("R13 no wake_go", seen, 0);
        chk("R13 dev_reset", dev_reset, 1);
        ext_rst_req = 1'b0; irq_flag = '0; irq_en = '0; gie = 1'b0; step(4);

        // R10 periodic clear avoids timeout
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            pulse_clr();
            for (int j = 0; j < 100; j++) begin step(1); if (dev_reset) seen = 1'b1; end
        end
        chk("R10 no timeout with clears", seen, 0);

        // R11 awake timeout
        pulse_clr(); n = 0;
        while (!dev_reset && n < 2000) begin step(1); n++; end
        chk("R11 timeout period", n, PERIOD);
        chk("R11 wdt_ok_stat", wdt_ok_stat, 0);
        chk("R11 awake_stat", awake_stat, 1);
        step(1);
        chk("R11 pulse width", dev_reset, 0);
        chk("R11 wdt restarted", wdt_count, 0);

        // R4/R6/R3 random trials
        for (int t = 0; t < 24; t++) begin
            logic [N_IRQ-1:0] en, pre;
            logic g;
            bit pend;
            int idx;
            en = N_IRQ'($urandom_range(1, (1 << N_IRQ) - 1));
            pre = N_IRQ'($urandom);
            g = 1'($urandom);
            gie = g; irq_en = en; irq_flag = pre; step(3);
            pend = exp_pending(en, pre);
            pulse_clr();
            ap = awake_stat;
            pulse_sleep();
            chk("R3/R2 random sleep taken", core_halt, !pend);
            if (pend) begin
                chk("R3 random awake_stat unchanged", awake_stat, ap);
            end else begin
                idx = 0;
                for (int k = 0; k < N_IRQ; k++) if (en[k]) idx = k;
                irq_flag = pre | N_IRQ'(1 << idx);
                wait_osc(n);
                chk("R4 random wake latency", n, 3);
                step(1);
                chk("R6 random vec path", wake_vec, g);
                chk("R5 random wake_go", wake_go, 1);
            end
            irq_flag = '0; irq_en = '0; step(4);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule